// File: doc/BRIEF.md
# Buffer Occupancy Monitor

This block tracks how full one stage of a hypothetical stream decoder's buffer chain would be, without holding any of the data. Two strobes, one for each byte that enters and one for each byte that leaves, drive a single up/down occupancy counter. A two-bit role code selects the buffer being modelled, and the role sets the size limit the occupancy is compared against. The video role takes its limit from an input value that the stream supplies.

Three sticky error flags report the conditions that make a stream undecodable. Overflow means the occupancy went past the limit. Underflow means a removal was requested from an empty buffer. Residence timeout means a tracked unit stayed in the buffer longer than allowed. A saturating error counter records each new error event. In the transport-packet role the block also marks which removed bytes are payload. It suppresses the header bytes at the start of each packet, so a downstream stage sees only the payload.

Top module: `occ_monitor`

## Requirements
- R1: After reset, occupancy is 0, all three flags are low, the error count is 0 and the payload strobe is low.
- R2: Occupancy equals bytes entered minus bytes removed. It changes on the clock edge that samples a strobe. When both strobes are high in the same cycle, the occupancy does not change.
- R3: The limit depends on the role code: 2'b00 gives 512 bytes, 2'b01 gives 1536 bytes, 2'b10 gives 3584 bytes, and 2'b11 gives var_size×2048 bytes. The overflow flag rises one edge after the occupancy first exceeds the limit.
- R4: A removal strobe without an entry strobe while the occupancy is 0 is rejected. The occupancy stays 0 and the underflow flag is set on that same edge.
- R5: After a unit-begin pulse, the delay flag is set two edges after TICKS_PER_SEC cycles have elapsed for a normal unit, or after 60×TICKS_PER_SEC cycles if the still-picture input was high at the unit-begin pulse.
- R6: A unit-end pulse that arrives before the timeout stops the residence timer, and no delay flag follows.
- R7: Flags are sticky. A clr pulse clears all flags and the error count. A condition that persists after the clear does not set its flag again.
- R8: The error count increases by one for each new event: each overflow crossing (counted once however long it lasts), each rejected removal, and each timeout.
- R9: In role 2'b00, the first 4 accepted removals of every 188 accepted removals produce no payload strobe. In every other role, each accepted removal produces a payload strobe one edge later. A rejected removal never produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate system clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears flags and error count |
| in_stb | input | 1 | One byte enters the buffer |
| out_stb | input | 1 | One byte leaves the buffer |
| role | input | 2 | Buffer role code |
| var_size | input | VSZ_W | Video size value, in units of 2048 bytes |
| still_pic | input | 1 | Unit being started is a still picture |
| unit_begin | input | 1 | First byte of a tracked unit entered |
| unit_end | input | 1 | Tracked unit fully removed |
| occupancy | output | OCC_W | Current fill level in bytes |
| payload_stb | output | 1 | Removed byte is payload |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |
| dly_flag | output | 1 | Sticky residence timeout |
| err_count | output | CNT_W | Saturating error-event count |

## Verification
The bench fills each role's buffer to exactly its limit and then adds one more byte. A design with an off-by-one comparison would flag overflow at the limit, or would miss the first byte past it. It removes bytes from an empty buffer: a design that wraps the counter would show a huge occupancy instead of 0. It holds an overflow across a clear, to catch a design that counts a persisting condition repeatedly or re-raises a cleared flag. It runs the residence timer on both sides of the normal and still-picture limits, and drives a full packet plus one more header through the transport role, so that a misplaced header window or a packet-position counter that does not wrap both show up as a wrong payload count.

// File: rtl/occmon_pkg.sv
package occmon_pkg;
  typedef enum logic [1:0] {
    ROLE_XPORT = 2'b00,
    ROLE_AUDIO = 2'b01,
    ROLE_SYS   = 2'b10,
    ROLE_VIDEO = 2'b11
  } role_e;

  localparam int XPORT_BYTES = 512;
  localparam int AUDIO_BYTES = 1536;
  localparam int SYS_BYTES   = 3584;
  localparam int VID_SHIFT   = 11;
  localparam int PKT_BYTES   = 188;
  localparam int HDR_BYTES   = 4;
endpackage

// File: rtl/occmon_limit.sv
module occmon_limit
  import occmon_pkg::*;
#(
  parameter int OCC_W = 24,
  parameter int VSZ_W = 10
) (
  input  logic [1:0]       role,
  input  logic [VSZ_W-1:0] var_size,
  output logic [OCC_W-1:0] limit
);
  role_e r;
  always_comb begin
    r = role_e'(role);
    unique case (r)
      ROLE_XPORT: limit = OCC_W'(XPORT_BYTES);
      ROLE_AUDIO: limit = OCC_W'(AUDIO_BYTES);
      ROLE_SYS:   limit = OCC_W'(SYS_BYTES);
      default:    limit = OCC_W'(var_size) << VID_SHIFT;
    endcase
  end
endmodule

// File: rtl/occmon_level.sv
module occmon_level #(
  parameter int OCC_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_stb,
  input  logic             out_stb,
  output logic [OCC_W-1:0] occ,
  output logic             removed,
  output logic             rejected
);
  logic inc, dec, empty, full;
  always_comb begin
    inc      = in_stb && !out_stb;
    dec      = out_stb && !in_stb;
    empty    = (occ == '0);
    full     = &occ;
    rejected = dec && empty;
    removed  = out_stb && (in_stb || !empty);
  end

  always_ff @(posedge clk) begin
    if (rst)                occ <= '0;
    else if (inc && !full)  occ <= occ + OCC_W'(1);
    else if (dec && !empty) occ <= occ - OCC_W'(1);
  end
endmodule

// File: rtl/occmon_timer.sv
module occmon_timer #(
  parameter int TICKS_PER_SEC = 27_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic unit_begin,
  input  logic unit_end,
  input  logic still_pic,
  output logic timeout
);
  localparam longint LIM_N = longint'(TICKS_PER_SEC);
  localparam longint LIM_S = longint'(TICKS_PER_SEC) * 60;
  localparam int     TW    = $clog2(LIM_S + 1);

  logic          active, still_q;
  logic [TW-1:0] cnt, lim;

  always_comb lim = still_q ? TW'(LIM_S) : TW'(LIM_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      still_q <= 1'b0;
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (unit_begin) begin
        active  <= 1'b1;
        still_q <= still_pic;
        cnt     <= '0;
      end else if (unit_end) begin
        active <= 1'b0;
      end else if (active) begin
        if (cnt == lim) begin
          active  <= 1'b0;
          timeout <= 1'b1;
        end else begin
          cnt <= cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/occmon_strip.sv
module occmon_strip
  import occmon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic is_xport,
  input  logic removed,
  output logic payload_stb
);
  localparam int PW = $clog2(PKT_BYTES);
  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos         <= '0;
      payload_stb <= 1'b0;
    end else begin
      payload_stb <= removed && (!is_xport || pos >= PW'(HDR_BYTES));
      if (removed && is_xport)
        pos <= (pos == PW'(PKT_BYTES - 1)) ? '0 : pos + PW'(1);
    end
  end
endmodule

// File: rtl/occ_monitor.sv
module occ_monitor
  import occmon_pkg::*;
#(
  parameter int OCC_W         = 24,
  parameter int VSZ_W         = 10,
  parameter int CNT_W         = 8,
  parameter int TICKS_PER_SEC = 27_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_stb,
  input  logic             out_stb,
  input  logic [1:0]       role,
  input  logic [VSZ_W-1:0] var_size,
  input  logic             still_pic,
  input  logic             unit_begin,
  input  logic             unit_end,
  output logic [OCC_W-1:0] occupancy,
  output logic             payload_stb,
  output logic             ovf_flag,
  output logic             udf_flag,
  output logic             dly_flag,
  output logic [CNT_W-1:0] err_count
);
  logic [OCC_W-1:0] limit;
  logic             removed, rejected, timeout;
  logic             ovf_prev, ovf_now, ovf_evt;
  logic [1:0]       n_evt;
  logic [CNT_W:0]   cnt_sum;

  occmon_limit #(.OCC_W(OCC_W), .VSZ_W(VSZ_W)) u_limit (
    .role(role), .var_size(var_size), .limit(limit));

  occmon_level #(.OCC_W(OCC_W)) u_level (
    .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb),
    .occ(occupancy), .removed(removed), .rejected(rejected));

  occmon_timer #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_timer (
    .clk(clk), .rst(rst), .unit_begin(unit_begin), .unit_end(unit_end),
    .still_pic(still_pic), .timeout(timeout));

  occmon_strip u_strip (
    .clk(clk), .rst(rst), .is_xport(role == ROLE_XPORT),
    .removed(removed), .payload_stb(payload_stb));

  always_comb begin
    ovf_now = occupancy > limit;
    ovf_evt = ovf_now && !ovf_prev;
    n_evt   = 2'(ovf_evt) + 2'(rejected) + 2'(timeout);
    cnt_sum = {1'b0, err_count} + (CNT_W+1)'(n_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_prev  <= 1'b0;
      ovf_flag  <= 1'b0;
      udf_flag  <= 1'b0;
      dly_flag  <= 1'b0;
      err_count <= '0;
    end else begin
      ovf_prev <= ovf_now;
      if (clr) begin
        ovf_flag  <= 1'b0;
        udf_flag  <= 1'b0;
        dly_flag  <= 1'b0;
        err_count <= '0;
      end else begin
        ovf_flag  <= ovf_flag | ovf_evt;
        udf_flag  <= udf_flag | rejected;
        dly_flag  <= dly_flag | timeout;
        err_count <= cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/occ_monitor_chk.sv
module occ_monitor_chk #(
  parameter int OCC_W = 24,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             in_stb,
  input logic             out_stb,
  input logic [1:0]       role,
  input logic [OCC_W-1:0] occupancy,
  input logic             payload_stb,
  input logic             ovf_flag,
  input logic             udf_flag,
  input logic             dly_flag,
  input logic [CNT_W-1:0] err_count
);
  p_both_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (in_stb && out_stb) |=> $stable(occupancy));

  p_inc_r2: assert property (@(posedge clk) disable iff (rst)
    (in_stb && !out_stb && !(&occupancy)) |=> occupancy == $past(occupancy) + OCC_W'(1));

  p_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (out_stb && !in_stb && occupancy == '0 && !clr) |=> (occupancy == '0 && udf_flag));

  p_cross_r3: assert property (@(posedge clk) disable iff (rst)
    (role == 2'b00 && $stable(role) && occupancy == OCC_W'(513) &&
     $past(occupancy) == OCC_W'(512) && !clr) |=> ovf_flag);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ((ovf_flag || udf_flag || dly_flag) && !clr) |=>
      (ovf_flag >= $past(ovf_flag) && udf_flag >= $past(udf_flag) && dly_flag >= $past(dly_flag)));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!ovf_flag && !udf_flag && !dly_flag && err_count == '0));

  p_count_mono_r8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> err_count >= $past(err_count));

  p_payload_r9: assert property (@(posedge clk) disable iff (rst)
    payload_stb |-> $past(out_stb));
endmodule

bind occ_monitor occ_monitor_chk #(.OCC_W(OCC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .in_stb(in_stb), .out_stb(out_stb),
  .role(role), .occupancy(occupancy), .payload_stb(payload_stb),
  .ovf_flag(ovf_flag), .udf_flag(udf_flag), .dly_flag(dly_flag),
  .err_count(err_count));

// File: tb/occ_monitor_test.sv
module occ_monitor_test;
  localparam int OCC_W = 24, VSZ_W = 10, CNT_W = 8, TPS = 10;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, in_stb = 1'b0, out_stb = 1'b0;
  logic [1:0] role = 2'b00;
  logic [VSZ_W-1:0] var_size = '0;
  logic still_pic = 1'b0, unit_begin = 1'b0, unit_end = 1'b0;
  logic [OCC_W-1:0] occupancy;
  logic payload_stb, ovf_flag, udf_flag, dly_flag;
  logic [CNT_W-1:0] err_count;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  occ_monitor #(.OCC_W(OCC_W), .VSZ_W(VSZ_W), .CNT_W(CNT_W), .TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst(rst), .clr(clr), .in_stb(in_stb), .out_stb(out_stb),
    .role(role), .var_size(var_size), .still_pic(still_pic),
    .unit_begin(unit_begin), .unit_end(unit_end), .occupancy(occupancy),
    .payload_stb(payload_stb), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
    .dly_flag(dly_flag), .err_count(err_count));

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(bit i, bit o);
    @(negedge clk); in_stb = i; out_stb = o;
    @(negedge clk); in_stb = 1'b0; out_stb = 1'b0;
  endtask

  task automatic push(int n);
    for (int k = 0; k < n; k++) pulse(1'b1, 1'b0);
  endtask

  task automatic do_reset(logic [1:0] r);
    @(negedge clk); rst = 1'b1; role = r;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    chk("R1", "occupancy", occupancy, 0);
    chk("R1", "flags", {ovf_flag, udf_flag, dly_flag}, 0);
    chk("R1", "err_count", err_count, 0);
    chk("R1", "payload", payload_stb, 0);
  endtask

  task automatic t_track();
    do_reset(2'b01);
    push(5);
    chk("R2", "after 5 in", occupancy, 5);
    pulse(1'b1, 1'b1);
    chk("R2", "both strobes", occupancy, 5);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    chk("R2", "after 2 out", occupancy, 3);
  endtask

  task automatic t_underflow();
    do_reset(2'b01);
    pulse(1'b0, 1'b1);
    chk("R4", "occupancy stays 0", occupancy, 0);
    chk("R4", "udf_flag", udf_flag, 1);
    pulse(1'b0, 1'b1);
    chk("R8", "two rejects", err_count, 2);
    pulse(1'b1, 1'b1);
    chk("R2", "both at empty", occupancy, 0);
    chk("R8", "no event on both", err_count, 2);
  endtask

  task automatic t_overflow(logic [1:0] r, int lim, int vs);
    do_reset(r);
    var_size = VSZ_W'(vs);
    push(lim);
    idle(1);
    chk("R3", "at limit no ovf", ovf_flag, 0);
    push(1);
    idle(1);
    chk("R3", "past limit ovf", ovf_flag, 1);
    chk("R8", "one crossing", err_count, 1);
  endtask

  task automatic t_persist_clear();
    t_overflow(2'b00, 512, 0);
    push(2);
    idle(2);
    chk("R8", "persisting ovf counted once", err_count, 1);
    chk("R7", "ovf sticky", ovf_flag, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R7", "ovf cleared", ovf_flag, 0);
    chk("R7", "count cleared", err_count, 0);
    idle(3);
    chk("R7", "no re-raise", ovf_flag, 0);
  endtask

  task automatic start_unit(bit still);
    @(negedge clk); unit_begin = 1'b1; still_pic = still;
    @(negedge clk); unit_begin = 1'b0; still_pic = 1'b0;
  endtask

  task automatic t_delay();
    do_reset(2'b00);
    start_unit(1'b0);
    idle(TPS);
    chk("R5", "normal before limit", dly_flag, 0);
    idle(3);
    chk("R5", "normal timeout", dly_flag, 1);
    chk("R8", "timeout counted", err_count, 1);
    do_reset(2'b00);
    start_unit(1'b1);
    idle(60 * TPS - 5);
    chk("R5", "still before limit", dly_flag, 0);
    idle(10);
    chk("R5", "still timeout", dly_flag, 1);
    do_reset(2'b00);
    start_unit(1'b0);
    idle(5);
    @(negedge clk); unit_end = 1'b1;
    @(negedge clk); unit_end = 1'b0;
    idle(20);
    chk("R6", "ended unit no timeout", dly_flag, 0);
  endtask

  task automatic t_header();
    int seen;
    do_reset(2'b00);
    push(200);
    seen = 0;
    for (int k = 0; k < 192; k++) begin
      pulse(1'b0, 1'b1);
      if (payload_stb) seen++;
    end
    chk("R9", "transport payload count", seen, 184);
    do_reset(2'b10);
    push(5);
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      pulse(1'b0, 1'b1);
      if (payload_stb) seen++;
    end
    chk("R9", "system role payload count", seen, 5);
  endtask

  initial begin
    t_reset();
    t_track();
    t_underflow();
    t_overflow(2'b01, 1536, 0);
    t_overflow(2'b10, 3584, 0);
    t_overflow(2'b11, 2048, 1);
    t_persist_clear();
    t_delay();
    t_header();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule